// File: doc/BRIEF.md
# SRAM-Style Host Adapter for an SDRAM Command Engine

This block connects a simple host bus with SRAM-like strobes to an SDRAM command engine. The host drives an active-low select, separate active-low read and write strobes, a 23-bit byte address, 32-bit write data and a 2-bit size code. The adapter stalls the host with an active-low busy output until the transfer has finished. Only one transfer is in flight at any time, and bursts are never issued.

On acceptance the adapter latches a command for the engine. The command holds the bank, row and column fields split from the byte address, the active-low per-lane data masks derived from the size and the low address bits, and the write data moved onto the addressed lanes. A write made while the mode-select input is low becomes a mode-register command carrying eleven data bits. Read data returned by the engine is moved down to the low-order lanes and kept in a holding register, so it stays valid after the stall ends. The `ALIGN` parameter, which defaults to 1, enables the lane moves. With `ALIGN` at 0 the data passes through unshifted.

Top module: `sdram_host_adapter`

## Requirements
- R1: While reset is held, and after it is released, `host_busy_n` is 1, `eng_req` is 0, `host_rdata` is 0 and `eng_dqm_n` is 4'b1111.
- R2: On the first rising edge that samples `host_cs_n` low together with `host_rd_n` or `host_wr_n` low, `host_busy_n` goes to 0 and `eng_req` goes to 1. Both hold until the engine reports completion. `eng_write` is 1 when `host_wr_n` was low.
- R3: After a transfer has finished, a host that keeps its strobes active does not start a second transfer. `eng_req` stays 0 and `host_busy_n` stays 1 until the select or both strobes have been seen inactive.
- R4: The edge that samples `eng_done` high during a request drops `eng_req`. `host_busy_n` goes back to 1 on the following edge.
- R5: Address bits 22:21 form `eng_bank`, bits 20:10 form `eng_row` and bits 9:2 form `eng_col`. These stay stable while `eng_req` is high.
- R6: Data masks are active low, with bit k covering bits 8k+7:8k. Size 0 and size 3 (word) give 4'b0000. Size 1 (byte) clears only bit addr[1:0]. Size 2 (half-word) gives 4'b1100 when addr[1] is 0 and 4'b0011 when it is 1.
- R7: With `ALIGN`=1 a byte write carries host data bits 7:0 in lane addr[1:0], and a half-word write carries bits 15:0 in the low half (addr[1]=0) or the high half (addr[1]=1). All other lanes are zero. A word write carries the data unchanged.
- R8: When a read completes, `host_rdata` takes the engine data of the addressed lane or half moved down to bit 0, with the upper bits zero, or the whole word for size 0 or 3. It then holds that value through later idle cycles and write transfers.
- R9: A write with `host_modeset_n` low sets `eng_modeset` to 1, `eng_dqm_n` to 4'b0000 and `eng_wdata` to host data bits 10:0 with the upper bits zero. A read with `host_modeset_n` low is an ordinary read with `eng_modeset` 0.
- R10: While `host_cs_n` is 1, the strobes have no effect. `host_busy_n` stays 1 and `eng_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_modeset_n | input | 1 | Marks a write as a mode-register write, active low |
| host_size | input | 2 | Transfer size: 0 word, 1 byte, 2 half-word, 3 word |
| host_addr | input | 23 | Byte address |
| host_wdata | input | 32 | Host write data |
| host_busy_n | output | 1 | Stall to the host, active low |
| host_rdata | output | 32 | Held read data |
| eng_req | output | 1 | Command pending to the engine |
| eng_write | output | 1 | Command is a write |
| eng_modeset | output | 1 | Command is a mode-register write |
| eng_bank | output | 2 | Bank field |
| eng_row | output | 11 | Row field |
| eng_col | output | 8 | Column field (32-bit word units) |
| eng_dqm_n | output | 4 | Per-lane data masks, active low |
| eng_wdata | output | 32 | Lane-placed write data |
| eng_done | input | 1 | Engine completion pulse |
| eng_rdata | input | 32 | Engine read data, valid with `eng_done` |

## Verification
The command fields, masks, write data, `eng_req` and the falling `host_busy_n` are all due one rising edge after the strobe is first seen. `eng_req` falls and `host_rdata` updates on the edge that samples `eng_done`. `host_busy_n` rises one edge later. The bench drives and samples on falling edges and checks each result at the first falling edge after the rising edge where it is due. It repeats the busy and request checks on every waiting cycle, and again while the host holds its strobes after the release.

// File: rtl/sha_pkg.sv
package sha_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int MODE_W = 11;

  localparam logic [1:0] SZ_WORD = 2'd0;
  localparam logic [1:0] SZ_BYTE = 2'd1;
  localparam logic [1:0] SZ_HALF = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RUN     = 2'd1,
    ST_FINISH  = 2'd2,
    ST_WAITOFF = 2'd3
  } sha_state_e;

  // Active-low lane enables for a transfer of the given size at byte offset lo.
  function automatic logic [LANES-1:0] lane_mask_n(logic [1:0] size, logic [1:0] lo);
    case (size)
      SZ_BYTE: return ~(LANES'(1) << lo);
      SZ_HALF: return ~(LANES'(3) << {lo[1], 1'b0});
      default: return '0;
    endcase
  endfunction

  // Moves low-order host data up to the addressed lanes.
  function automatic logic [DATA_W-1:0] steer_up(logic [1:0] size, logic [1:0] lo,
                                                 logic [DATA_W-1:0] d);
    case (size)
      SZ_BYTE: return DATA_W'(d[7:0]) << {lo, 3'b000};
      SZ_HALF: return DATA_W'(d[15:0]) << {lo[1], 4'b0000};
      default: return d;
    endcase
  endfunction

  // Moves the addressed lanes of engine data down to bit 0.
  function automatic logic [DATA_W-1:0] steer_down(logic [1:0] size, logic [1:0] lo,
                                                   logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] sh;
    case (size)
      SZ_BYTE: begin
        sh = d >> {lo, 3'b000};
        return {{(DATA_W-8){1'b0}}, sh[7:0]};
      end
      SZ_HALF: begin
        sh = d >> {lo[1], 4'b0000};
        return {{(DATA_W-16){1'b0}}, sh[15:0]};
      end
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/sha_decode.sv
module sha_decode #(
  parameter int COL_W  = 8,
  parameter int ROW_W  = 11,
  parameter int BANK_W = 2,
  localparam int ADDR_W = 2 + COL_W + ROW_W + BANK_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic [1:0]        lo
);
  localparam int COL_LSB  = 2;
  localparam int ROW_LSB  = COL_LSB + COL_W;
  localparam int BANK_LSB = ROW_LSB + ROW_W;

  assign lo   = addr[1:0];
  assign col  = addr[COL_LSB  +: COL_W];
  assign row  = addr[ROW_LSB  +: ROW_W];
  assign bank = addr[BANK_LSB +: BANK_W];
endmodule

// File: rtl/sha_lanes.sv
module sha_lanes
  import sha_pkg::*;
#(
  parameter bit ALIGN = 1'b1
) (
  input  logic [1:0]        size,
  input  logic [1:0]        lo,
  input  logic              mode_wr,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [LANES-1:0]  dqm_n,
  output logic [DATA_W-1:0] wdata_out
);
  logic [DATA_W-1:0] placed;

  generate
    if (ALIGN) begin : g_align
      assign placed = steer_up(size, lo, wdata_in);
    end else begin : g_raw
      assign placed = wdata_in;
    end
  endgenerate

  always_comb begin
    if (mode_wr) begin
      dqm_n     = '0;
      wdata_out = {{(DATA_W-MODE_W){1'b0}}, wdata_in[MODE_W-1:0]};
    end else begin
      dqm_n     = lane_mask_n(size, lo);
      wdata_out = placed;
    end
  end
endmodule

// File: rtl/sha_ctrl.sv
module sha_ctrl
  import sha_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_seen,
  input  logic eng_done,
  output logic busy_n,
  output logic eng_req,
  output logic accept,
  output logic capture
);
  sha_state_e state, state_nx;
  logic finishing;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:    if (req_seen)  state_nx = ST_RUN;
      ST_RUN:     if (eng_done)  state_nx = ST_FINISH;
      ST_FINISH:                 state_nx = ST_WAITOFF;
      ST_WAITOFF: if (!req_seen) state_nx = ST_IDLE;
      default:                   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign accept    = (state == ST_IDLE) && req_seen;
  assign capture   = (state == ST_RUN) && eng_done;
  assign finishing = (state == ST_FINISH);
  assign eng_req   = (state == ST_RUN);
  assign busy_n    = !((state == ST_RUN) || (state == ST_FINISH));

  // R2: a seen request stalls the host and raises the command at the next edge
  p_busy_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!busy_n && eng_req));

  // R4: completion drops the request but keeps the stall for one more cycle
  p_done_drops_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (!busy_n && !eng_req));

  // R4: stall released one cycle after completion
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    finishing |=> busy_n);

  // R3: held strobes after a release start no new transfer
  p_single_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAITOFF && req_seen) |=> (!eng_req && busy_n));
endmodule

// File: rtl/sdram_host_adapter.sv
module sdram_host_adapter
  import sha_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int ROW_W  = 11,
  parameter int BANK_W = 2,
  parameter bit ALIGN  = 1'b1,
  localparam int ADDR_W = 2 + COL_W + ROW_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              host_modeset_n,
  input  logic [1:0]        host_size,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_busy_n,
  output logic [DATA_W-1:0] host_rdata,
  output logic              eng_req,
  output logic              eng_write,
  output logic              eng_modeset,
  output logic [BANK_W-1:0] eng_bank,
  output logic [ROW_W-1:0]  eng_row,
  output logic [COL_W-1:0]  eng_col,
  output logic [LANES-1:0]  eng_dqm_n,
  output logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rdata
);
  // Named internal events
  logic req_seen, accept, capture, mode_wr;
  logic [BANK_W-1:0] d_bank;
  logic [ROW_W-1:0]  d_row;
  logic [COL_W-1:0]  d_col;
  logic [1:0]        d_lo;
  logic [LANES-1:0]  l_dqm_n;
  logic [DATA_W-1:0] l_wdata;
  logic [1:0]        size_q;
  logic [1:0]        lo_q;
  logic [DATA_W-1:0] rd_placed;

  assign req_seen = !host_cs_n && (!host_rd_n || !host_wr_n);
  assign mode_wr  = !host_wr_n && !host_modeset_n;

  sha_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_seen (req_seen),
    .eng_done (eng_done),
    .busy_n   (host_busy_n),
    .eng_req  (eng_req),
    .accept   (accept),
    .capture  (capture)
  );

  sha_decode #(.COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_decode (
    .addr (host_addr),
    .bank (d_bank),
    .row  (d_row),
    .col  (d_col),
    .lo   (d_lo)
  );

  sha_lanes #(.ALIGN(ALIGN)) u_lanes (
    .size      (host_size),
    .lo        (d_lo),
    .mode_wr   (mode_wr),
    .wdata_in  (host_wdata),
    .dqm_n     (l_dqm_n),
    .wdata_out (l_wdata)
  );

  // Command latch, loaded once per accepted transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_write   <= 1'b0;
      eng_modeset <= 1'b0;
      eng_bank    <= '0;
      eng_row     <= '0;
      eng_col     <= '0;
      eng_dqm_n   <= '1;
      eng_wdata   <= '0;
      size_q      <= SZ_WORD;
      lo_q        <= 2'd0;
    end else if (accept) begin
      eng_write   <= !host_wr_n;
      eng_modeset <= mode_wr;
      eng_bank    <= d_bank;
      eng_row     <= d_row;
      eng_col     <= d_col;
      eng_dqm_n   <= l_dqm_n;
      eng_wdata   <= l_wdata;
      size_q      <= host_size;
      lo_q        <= d_lo;
    end
  end

  generate
    if (ALIGN) begin : g_rd_align
      assign rd_placed = steer_down(size_q, lo_q, eng_rdata);
    end else begin : g_rd_raw
      assign rd_placed = eng_rdata;
    end
  endgenerate

  // Read holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    host_rdata <= '0;
    else if (capture && !eng_write) host_rdata <= rd_placed;
  end

  // R8: held read data changes only at a completion edge
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(host_rdata));

  // R5: command fields stay put while the request is pending
  p_fields_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && $past(eng_req)) |-> $stable({eng_bank, eng_row, eng_col, eng_dqm_n}));

  // R6: a byte command enables exactly one lane
  p_byte_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_modeset && size_q == SZ_BYTE) |-> ($countones(~eng_dqm_n) == 1));

  // R9: a mode-register command is a full-lane write with only the low field set
  p_mode_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_modeset) |-> (eng_write && eng_dqm_n == '0 &&
                                  eng_wdata[DATA_W-1:MODE_W] == '0));

  // R10: no command can be pending while the host is deselected and idle
  p_no_cmd_unselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busy_n && host_cs_n) |=> !eng_req);
endmodule

// File: tb/tb_sdram_host_adapter.sv
module tb_sdram_host_adapter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_modeset_n = 1'b1;
  logic [1:0]  host_size = 2'd0;
  logic [22:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_busy_n;
  logic [31:0] host_rdata;
  logic        eng_req, eng_write, eng_modeset;
  logic [1:0]  eng_bank;
  logic [10:0] eng_row;
  logic [7:0]  eng_col;
  logic [3:0]  eng_dqm_n;
  logic [31:0] eng_wdata;
  logic        eng_done = 1'b0;
  logic [31:0] eng_rdata = '0;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] held_rd = '0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_host_adapter dut (
    .clk(clk), .rst_n(rst_n),
    .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_modeset_n(host_modeset_n), .host_size(host_size),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_busy_n(host_busy_n), .host_rdata(host_rdata),
    .eng_req(eng_req), .eng_write(eng_write), .eng_modeset(eng_modeset),
    .eng_bank(eng_bank), .eng_row(eng_row), .eng_col(eng_col),
    .eng_dqm_n(eng_dqm_n), .eng_wdata(eng_wdata),
    .eng_done(eng_done), .eng_rdata(eng_rdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_mask(logic [1:0] sz, logic [1:0] lo);
    if (sz == 2'd1) begin
      case (lo)
        2'd0: return 4'b1110;
        2'd1: return 4'b1101;
        2'd2: return 4'b1011;
        default: return 4'b0111;
      endcase
    end else if (sz == 2'd2) return lo[1] ? 4'b0011 : 4'b1100;
    return 4'b0000;
  endfunction

  function automatic logic [31:0] exp_wd(logic [1:0] sz, logic [1:0] lo, logic [31:0] d);
    if (sz == 2'd1) begin
      case (lo)
        2'd0: return {24'h0, d[7:0]};
        2'd1: return {16'h0, d[7:0], 8'h0};
        2'd2: return {8'h0, d[7:0], 16'h0};
        default: return {d[7:0], 24'h0};
      endcase
    end else if (sz == 2'd2) return lo[1] ? {d[15:0], 16'h0} : {16'h0, d[15:0]};
    return d;
  endfunction

  function automatic logic [31:0] exp_rd(logic [1:0] sz, logic [1:0] lo, logic [31:0] d);
    if (sz == 2'd1) begin
      case (lo)
        2'd0: return {24'h0, d[7:0]};
        2'd1: return {24'h0, d[15:8]};
        2'd2: return {24'h0, d[23:16]};
        default: return {24'h0, d[31:24]};
      endcase
    end else if (sz == 2'd2) return lo[1] ? {16'h0, d[31:16]} : {16'h0, d[15:0]};
    return d;
  endfunction

  task automatic xfer(logic [22:0] a, logic [1:0] sz, bit wr, bit ms,
                      logic [31:0] wd, int dly, logic [31:0] rd);
    bit mode = wr && ms;
    @(negedge clk);
    host_addr = a; host_size = sz; host_wdata = wd;
    host_modeset_n = !ms; host_cs_n = 1'b0;
    host_rd_n = wr; host_wr_n = !wr;
    @(negedge clk);
    chk("R2 busy on accept", 32'(host_busy_n), 32'd0);
    chk("R2 req on accept", 32'(eng_req), 32'd1);
    chk("R2 write flag", 32'(eng_write), 32'(wr));
    chk("R5 bank", 32'(eng_bank), 32'(a[22:21]));
    chk("R5 row", 32'(eng_row), 32'(a[20:10]));
    chk("R5 col", 32'(eng_col), 32'(a[9:2]));
    chk("R9 modeset flag", 32'(eng_modeset), 32'(mode));
    if (mode) begin
      chk("R9 mode masks", 32'(eng_dqm_n), 32'd0);
      chk("R9 mode data", eng_wdata, {21'h0, wd[10:0]});
    end else begin
      chk("R6 masks", 32'(eng_dqm_n), 32'(exp_mask(sz, a[1:0])));
      if (wr) chk("R7 write lanes", eng_wdata, exp_wd(sz, a[1:0], wd));
    end
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk("R2 busy held", 32'(host_busy_n), 32'd0);
      chk("R2 req held", 32'(eng_req), 32'd1);
    end
    eng_done = 1'b1; eng_rdata = rd;
    @(negedge clk);
    eng_done = 1'b0; eng_rdata = $urandom;
    chk("R4 req drops at done", 32'(eng_req), 32'd0);
    chk("R4 busy one more cycle", 32'(host_busy_n), 32'd0);
    if (!wr) held_rd = exp_rd(sz, a[1:0], rd);
    chk("R8 read data", host_rdata, held_rd);
    @(negedge clk);
    chk("R4 busy released", 32'(host_busy_n), 32'd1);
    @(negedge clk);
    chk("R3 no second xfer busy", 32'(host_busy_n), 32'd1);
    chk("R3 no second xfer req", 32'(eng_req), 32'd0);
    host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1; host_modeset_n = 1'b1;
    @(negedge clk);
    chk("R8 read data held", host_rdata, held_rd);
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      vectors++; errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(host_busy_n), 32'd1);
    chk("R1 req in reset", 32'(eng_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 32'(host_busy_n), 32'd1);
    chk("R1 req after reset", 32'(eng_req), 32'd0);
    chk("R1 rdata after reset", host_rdata, 32'd0);
    chk("R1 masks after reset", 32'(eng_dqm_n), 32'hF);

    // R10: deselected strobes ignored
    host_cs_n = 1'b1; host_rd_n = 1'b0; host_wr_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 busy unselected", 32'(host_busy_n), 32'd1);
      chk("R10 req unselected", 32'(eng_req), 32'd0);
    end
    host_rd_n = 1'b1; host_wr_n = 1'b1;

    // Directed corners
    for (int l = 0; l < 4; l++)
      xfer(23'h2A5400 | 23'(l), 2'd1, 1'b0, 1'b0, 32'h0, l, 32'hA1B2C3D4);
    xfer(23'h000002, 2'd2, 1'b0, 1'b0, 32'h0, 1, 32'h89AB4567);
    xfer(23'h000000, 2'd2, 1'b1, 1'b0, 32'hFFFF1234, 0, 32'h0);
    xfer(23'h7FFFFF, 2'd1, 1'b1, 1'b0, 32'h000000EE, 2, 32'h0);
    xfer(23'h7FFFFC, 2'd3, 1'b0, 1'b0, 32'h0, 0, 32'hCAFEF00D);
    xfer(23'h123454, 2'd0, 1'b1, 1'b1, 32'hFFFFF7A5, 1, 32'h0);
    xfer(23'h000010, 2'd0, 1'b0, 1'b1, 32'h0, 0, 32'h5A5A0F0F);

    // Constrained random
    for (int n = 0; n < 60; n++) begin
      logic [22:0] a = 23'($urandom);
      logic [1:0]  s = 2'($urandom);
      bit          w = 1'($urandom);
      bit          m = ($urandom % 8) == 0;
      xfer(a, s, w, m, $urandom, int'($urandom % 4), $urandom);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule